// File: doc/BRIEF.md
# Bus Width Down-Conversion Sequencer

This block sits between a 32-bit host slave port and one external peripheral whose data path is 8, 16 or 32 bits wide. A single host read or write is turned into one or more narrow peripheral cycles. For each narrow cycle the block drives the matching low address bits and places the right byte lane of the host word on the peripheral data bus. On reads it collects the returned lanes into one host word. When the peripheral accepts the final narrow cycle, the block returns one data acknowledge to the host.

A build-time enable selects the splitting behaviour. With the enable on, a narrow device is given as many sub-cycles as needed to cover the host word. With it off, the device gets a single unsplit cycle at the address the host supplied. Lane numbering is big-endian. The most significant byte of the host word belongs to the lowest address and goes out first.

The block does not decode the host protocol, cross clock domains or shape the peripheral strobes. Its neighbours provide those functions.

Top module: `wdown_seq`

## Requirements
- R1: The peripheral width parameter `PER_DW` accepts only 8, 16 or 32. Any other value stops elaboration. A 32-bit device always gets exactly one cycle, and its address equals the host address.
- R2: With the split enable set, one host access produces exactly four accepted peripheral cycles on an 8-bit device and exactly two on a 16-bit device. The acknowledge follows the last of them.
- R3: In split mode, sub-cycle k (counting from 0) drives the peripheral address with bits [1:0] equal to k times the device byte count, modulo 4. The upper bits are the host address bits.
- R4: For writes, sub-cycle k drives the host data slice [31-k·W : 32-(k+1)·W], where W is the device width. The most significant lane therefore goes first. `per_wr` equals the host write flag.
- R5: While a sub-cycle is outstanding and `per_accept` is low, `per_req`, `per_addr` and `per_wdata` hold their values. The next sub-cycle starts only in the clock after an accept.
- R6: `host_ack` is high for exactly one clock. It comes in the clock after the accept of the final sub-cycle and never after an intermediate one.
- R7: With the split enable clear, every access is a single peripheral cycle whose address equals the host address. Its lane index is host address bits [1:0] shifted right by log2 of the device byte count.
- R8: On a read, each accepted lane is stored at its lane position in a holding word, and lanes that no cycle filled read as zero. The assembled word is valid on `host_rdata` while `host_ack` is high.
- R9: A host request that arrives while an access is in progress or while the acknowledge is high is dropped. It starts no peripheral cycle and produces no acknowledge.
- R10: Synchronous active-high reset clears the sub-cycle counter and the holding word. After reset, `per_req`, `host_ack` and `host_rdata` are all zero.
- R11: `per_accept` pulses that arrive while no sub-cycle is outstanding are ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| host_req | input | 1 | One-clock host access request |
| host_wr | input | 1 | 1 = write, 0 = read |
| host_addr | input | AW | Host byte address |
| host_wdata | input | 32 | Host write word, bit 31 is the first lane |
| host_ack | output | 1 | One-clock data acknowledge |
| host_rdata | output | 32 | Assembled read word, valid with host_ack |
| per_req | output | 1 | Peripheral sub-cycle outstanding |
| per_wr | output | 1 | Peripheral write flag |
| per_addr | output | AW | Peripheral byte address |
| per_wdata | output | PER_DW | Peripheral write lane |
| per_rdata | input | PER_DW | Peripheral read lane, sampled with per_accept |
| per_accept | input | 1 | One-clock pulse: peripheral took the sub-cycle |

## Verification
The bench builds five copies with `AW` = 16: 8-bit and 16-bit devices with splitting on, the same two widths with splitting off, and a 32-bit device with splitting on. Together they reach four-lane and two-lane sequencing, every unsplit lane position chosen from the address, and the 32-bit case where the split enable must have no effect. Random accept latency of 0 to 2 clocks, stray accepts while idle, and a second request during a running access all apply to every copy at once.

// File: rtl/wdown_pkg.sv
package wdown_pkg;

    localparam int HOST_DW    = 32;
    localparam int HOST_BYTES = HOST_DW / 8;
    localparam int OFF_W      = 2;

    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_RUN  = 2'd1,
        ST_DONE = 2'd2
    } seq_state_e;

    // Latched host request contents used by the lane datapath
    typedef struct packed {
        logic               wr;
        logic [HOST_DW-1:0] data;
    } req_info_t;

    function automatic int lanes_of(input int per_dw);
        return HOST_DW / per_dw;
    endfunction

    function automatic int sub_total(input int per_dw, input bit split_en);
        return (split_en && lanes_of(per_dw) > 1) ? lanes_of(per_dw) : 1;
    endfunction

    function automatic int byte_shift(input int per_dw);
        return $clog2(per_dw / 8);
    endfunction

endpackage

// File: rtl/wdown_ctrl.sv
module wdown_ctrl
    import wdown_pkg::*;
#(
    parameter int SUBS = 4
) (
    input  logic       clk,
    input  logic       rst,
    input  logic       host_req,
    input  logic       per_accept,
    output seq_state_e state,
    output logic [1:0] sub_idx,
    output logic       start,
    output logic       take
);

    localparam logic [1:0] LAST_IDX = 2'(SUBS - 1);

    always_comb begin
        start = (state == ST_IDLE) && host_req;
        take  = (state == ST_RUN) && per_accept;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state   <= ST_IDLE;
            sub_idx <= '0;
        end else begin
            case (state)
                ST_IDLE: begin
                    sub_idx <= '0;
                    if (host_req) state <= ST_RUN;
                end
                ST_RUN: begin
                    if (per_accept) begin
                        if (sub_idx == LAST_IDX) state <= ST_DONE;
                        else                     sub_idx <= sub_idx + 2'd1;
                    end
                end
                ST_DONE: begin
                    state   <= ST_IDLE;
                    sub_idx <= '0;
                end
                default: state <= ST_IDLE;
            endcase
        end
    end

endmodule

// File: rtl/wdown_addr_gen.sv
module wdown_addr_gen
    import wdown_pkg::*;
#(
    parameter int AW     = 16,
    parameter int PER_DW = 8,
    parameter bit SPLIT  = 1'b1
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          start,
    input  logic [AW-1:0] host_addr,
    input  logic [1:0]    sub_idx,
    output logic [AW-1:0] per_addr,
    output logic [1:0]    lane
);

    localparam int SH = byte_shift(PER_DW);

    logic [AW-1:0]    base_q;
    logic [OFF_W-1:0] gen_off;

    always_ff @(posedge clk) begin
        if (rst)        base_q <= '0;
        else if (start) base_q <= host_addr;
    end

    always_comb begin
        gen_off  = sub_idx << SH;
        per_addr = SPLIT ? {base_q[AW-1:OFF_W], gen_off} : base_q;
        lane     = SPLIT ? sub_idx : (base_q[OFF_W-1:0] >> SH);
    end

endmodule

// File: rtl/wdown_lane_steer.sv
module wdown_lane_steer
    import wdown_pkg::*;
#(
    parameter int PER_DW = 8
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               start,
    input  logic               host_wr,
    input  logic [HOST_DW-1:0] host_wdata,
    input  logic               take,
    input  logic [1:0]         lane,
    input  logic [PER_DW-1:0]  per_rdata,
    output logic               per_wr,
    output logic [PER_DW-1:0]  per_wdata,
    output logic [HOST_DW-1:0] host_rdata
);

    localparam int NL = lanes_of(PER_DW);

    req_info_t         cur_q;
    logic [PER_DW-1:0] wr_lane [NL];
    logic [PER_DW-1:0] rd_lane [NL];

    always_ff @(posedge clk) begin
        if (rst)        cur_q <= '0;
        else if (start) cur_q <= '{wr: host_wr, data: host_wdata};
    end

    assign per_wr = cur_q.wr;

    for (genvar g = 0; g < NL; g++) begin : g_lane
        localparam int TOP = HOST_DW - 1 - g * PER_DW;

        assign wr_lane[g] = cur_q.data[TOP -: PER_DW];

        always_ff @(posedge clk) begin
            if (rst || start)
                rd_lane[g] <= '0;
            else if (take && !cur_q.wr && lane == 2'(g))
                rd_lane[g] <= per_rdata;
        end

        assign host_rdata[TOP -: PER_DW] = rd_lane[g];
    end

    always_comb begin
        per_wdata = '0;
        for (int g = 0; g < NL; g++) begin
            if (lane == 2'(g)) per_wdata = per_wdata | wr_lane[g];
        end
    end

endmodule

// File: rtl/wdown_seq.sv
module wdown_seq
    import wdown_pkg::*;
#(
    parameter int AW       = 16,
    parameter int PER_DW   = 8,
    parameter bit MATCH_EN = 1'b1
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               host_req,
    input  logic               host_wr,
    input  logic [AW-1:0]      host_addr,
    input  logic [HOST_DW-1:0] host_wdata,
    output logic               host_ack,
    output logic [HOST_DW-1:0] host_rdata,
    output logic               per_req,
    output logic               per_wr,
    output logic [AW-1:0]      per_addr,
    output logic [PER_DW-1:0]  per_wdata,
    input  logic [PER_DW-1:0]  per_rdata,
    input  logic               per_accept
);

    localparam int NL    = lanes_of(PER_DW);
    localparam bit SPLIT = MATCH_EN && (NL > 1);
    localparam int SUBS  = sub_total(PER_DW, MATCH_EN);

    if (PER_DW != 8 && PER_DW != 16 && PER_DW != 32) begin : g_bad_width
        $error("wdown_seq: PER_DW must be 8, 16 or 32 (R1)");
    end

    seq_state_e state;
    logic [1:0] sub_idx;
    logic [1:0] lane;
    logic       start;
    logic       take;

    wdown_ctrl #(.SUBS(SUBS)) u_ctrl (
        .clk        (clk),
        .rst        (rst),
        .host_req   (host_req),
        .per_accept (per_accept),
        .state      (state),
        .sub_idx    (sub_idx),
        .start      (start),
        .take       (take)
    );

    wdown_addr_gen #(.AW(AW), .PER_DW(PER_DW), .SPLIT(SPLIT)) u_addr (
        .clk       (clk),
        .rst       (rst),
        .start     (start),
        .host_addr (host_addr),
        .sub_idx   (sub_idx),
        .per_addr  (per_addr),
        .lane      (lane)
    );

    wdown_lane_steer #(.PER_DW(PER_DW)) u_steer (
        .clk        (clk),
        .rst        (rst),
        .start      (start),
        .host_wr    (host_wr),
        .host_wdata (host_wdata),
        .take       (take),
        .lane       (lane),
        .per_rdata  (per_rdata),
        .per_wr     (per_wr),
        .per_wdata  (per_wdata),
        .host_rdata (host_rdata)
    );

    assign per_req  = (state == ST_RUN);
    assign host_ack = (state == ST_DONE);

endmodule

// File: rtl/wdown_seq_chk.sv
module wdown_seq_chk
    import wdown_pkg::*;
#(
    parameter int AW       = 16,
    parameter int PER_DW   = 8,
    parameter bit MATCH_EN = 1'b1
) (
    input logic              clk,
    input logic              rst,
    input logic              host_req,
    input logic              host_ack,
    input logic              per_req,
    input logic              per_accept,
    input logic [AW-1:0]     per_addr,
    input logic [PER_DW-1:0] per_wdata
);

    localparam int NL    = lanes_of(PER_DW);
    localparam bit SPLIT = MATCH_EN && (NL > 1);
    localparam int SUBS  = sub_total(PER_DW, MATCH_EN);
    localparam int SH    = byte_shift(PER_DW);

    // Accepted sub-cycles since the last acknowledge
    logic [2:0] acc_cnt;
    logic [1:0] exp_off;

    always_ff @(posedge clk) begin
        if (rst || host_ack)          acc_cnt <= '0;
        else if (per_req && per_accept) acc_cnt <= acc_cnt + 3'd1;
    end

    assign exp_off = acc_cnt[1:0] << SH;

    p_count_r2: assert property (@(posedge clk) disable iff (rst)
        host_ack |-> acc_cnt == 3'(SUBS));

    if (SPLIT) begin : g_split_chk
        p_low_addr_r3: assert property (@(posedge clk) disable iff (rst)
            per_req |-> per_addr[1:0] == exp_off);
    end

    p_hold_r5: assert property (@(posedge clk) disable iff (rst)
        (per_req && !per_accept) |=> (per_req && $stable(per_addr) && $stable(per_wdata)));

    p_ack_pulse_r6: assert property (@(posedge clk) disable iff (rst)
        host_ack |=> !host_ack);

    p_ack_after_accept_r6: assert property (@(posedge clk) disable iff (rst)
        host_ack |-> ($past(per_accept) && $past(per_req)));

    p_drop_req_r9: assert property (@(posedge clk) disable iff (rst)
        (host_ack && host_req) |=> !per_req);

    p_reset_r10: assert property (@(posedge clk)
        rst |=> (!host_ack && !per_req));

endmodule

bind wdown_seq wdown_seq_chk #(
    .AW       (AW),
    .PER_DW   (PER_DW),
    .MATCH_EN (MATCH_EN)
) u_chk (
    .clk        (clk),
    .rst        (rst),
    .host_req   (host_req),
    .host_ack   (host_ack),
    .per_req    (per_req),
    .per_accept (per_accept),
    .per_addr   (per_addr),
    .per_wdata  (per_wdata)
);

// File: tb/wdown_seq_tb.sv
module wdown_seq_tb;

    localparam int AW = 16;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic          host_req = 1'b0;
    logic          host_wr = 1'b0;
    logic [AW-1:0] host_addr = '0;
    logic [31:0]   host_wdata = '0;

    // Intended transaction, as the bench expects the DUTs to see it
    logic          tx_wr = 1'b0;
    logic [AW-1:0] tx_addr = '0;
    logic [31:0]   tx_wdata = '0;
    logic          tx_start = 1'b0;
    logic          chk_rst = 1'b0;

    int n_wd = 0;

    always #5 clk = ~clk;

    function automatic logic [31:0] lane_mask(input int pw);
        return (pw == 32) ? 32'hFFFF_FFFF : ((32'h1 << pw) - 32'h1);
    endfunction

    function automatic logic [31:0] lane_of(input logic [31:0] w, input int ln, input int pw);
        return (w >> (32 - (ln + 1) * pw)) & lane_mask(pw);
    endfunction

    for (genvar i = 0; i < 5; i++) begin : g_dut
        localparam int PW   = (i == 1 || i == 3) ? 16 : ((i == 4) ? 32 : 8);
        localparam bit MT   = (i != 2 && i != 3);
        localparam int NL   = 32 / PW;
        localparam bit SPL  = MT && (NL > 1);
        localparam int SUBS = SPL ? NL : 1;
        localparam int SH   = (PW == 8) ? 0 : ((PW == 16) ? 1 : 2);

        logic          host_ack, per_req, per_wr;
        logic [31:0]   host_rdata;
        logic [AW-1:0] per_addr;
        logic [PW-1:0] per_wdata;
        logic [PW-1:0] per_rdata = '0;
        logic          per_accept = 1'b0;

        int          n_chk = 0;
        int          n_bad = 0;
        int          k = 0;
        int          wt = 0;
        bit          done = 1'b0;
        bit          prev_ack = 1'b0;
        logic [31:0] exp_rd = '0;

        wdown_seq #(.AW(AW), .PER_DW(PW), .MATCH_EN(MT)) u_dut (
            .clk        (clk),
            .rst        (rst),
            .host_req   (host_req),
            .host_wr    (host_wr),
            .host_addr  (host_addr),
            .host_wdata (host_wdata),
            .host_ack   (host_ack),
            .host_rdata (host_rdata),
            .per_req    (per_req),
            .per_wr     (per_wr),
            .per_addr   (per_addr),
            .per_wdata  (per_wdata),
            .per_rdata  (per_rdata),
            .per_accept (per_accept)
        );

        task automatic chk(input bit ok, input string rq, input logic [31:0] act, input logic [31:0] exp);
            n_chk++;
            if (!ok) begin
                n_bad++;
                $display("FAIL %s cfg%0d (w=%0d split=%0d): actual %h expected %h",
                         rq, i, PW, SPL, act, exp);
            end
        endtask

        initial begin
            forever begin
                @(posedge clk);
                #2;
                per_accept = 1'b0;
                if (chk_rst) begin
                    // R10: outputs after reset
                    chk(!per_req && !host_ack && host_rdata == 32'h0, "R10",
                        {host_rdata[29:0], per_req, host_ack}, 32'h0);
                    done = 1'b0;
                    prev_ack = 1'b0;
                end else if (!rst) begin
                    if (tx_start) begin
                        k = 0;
                        wt = $urandom % 3;
                        exp_rd = '0;
                        done = 1'b0;
                    end
                    if (host_ack) begin
                        chk(!prev_ack, "R6 single-clock ack", 32'(prev_ack), 32'h0);
                        chk(!done, "R9 no second ack", 32'(done), 32'h0);
                        chk(k == SUBS, SPL ? "R2 sub-cycle count" : "R7 single cycle",
                            32'(k), 32'(SUBS));
                        if (!tx_wr)
                            chk(host_rdata == exp_rd, "R8 read gather", host_rdata, exp_rd);
                        done = 1'b1;
                    end
                    if (per_req) begin
                        int          ln;
                        logic [AW-1:0] ea;
                        logic [31:0] rd;
                        chk(!done, "R9 dropped request started a cycle", 32'(per_addr), 32'h0);
                        ln = SPL ? k : int'(tx_addr[1:0] >> SH);
                        ea = SPL ? {tx_addr[AW-1:2], 2'((k << SH) & 3)} : tx_addr;
                        chk(per_addr == ea,
                            (PW == 32) ? "R1 32-bit address" : (SPL ? "R3 address" : "R7 address"),
                            32'(per_addr), 32'(ea));
                        chk(per_wr == tx_wr, "R4 write flag", 32'(per_wr), 32'(tx_wr));
                        if (tx_wr)
                            chk(32'(per_wdata) == lane_of(tx_wdata, ln, PW), "R4 write lane",
                                32'(per_wdata), lane_of(tx_wdata, ln, PW));
                        if (wt == 0) begin
                            // R5: the next sub-cycle is checked only after this accept
                            rd = $urandom & lane_mask(PW);
                            per_rdata = PW'(rd);
                            per_accept = 1'b1;
                            exp_rd = exp_rd | (rd << (32 - (ln + 1) * PW));
                            k++;
                            wt = $urandom % 3;
                        end else begin
                            wt--;
                        end
                    end else if ($urandom % 4 == 0) begin
                        // R11: stray accept while nothing is outstanding
                        per_rdata = PW'($urandom);
                        per_accept = 1'b1;
                    end
                    prev_ack = host_ack;
                end
            end
        end
    end

    function automatic bit all_done();
        return g_dut[0].done && g_dut[1].done && g_dut[2].done && g_dut[3].done && g_dut[4].done;
    endfunction

    task automatic do_reset();
        rst = 1'b1;
        repeat (2) @(posedge clk);
        #1 chk_rst = 1'b1;
        @(posedge clk);
        #1 chk_rst = 1'b0;
        rst = 1'b0;
    endtask

    task automatic run_tx(input bit wr, input logic [AW-1:0] a, input logic [31:0] d, input bit spur);
        int cyc;
        @(posedge clk);
        #1;
        tx_wr = wr; tx_addr = a; tx_wdata = d;
        host_wr = wr; host_addr = a; host_wdata = d;
        host_req = 1'b1; tx_start = 1'b1;
        @(posedge clk);
        #1;
        tx_start = 1'b0;
        if (spur) begin
            // R9: a second request while the first is running
            host_addr = a ^ 16'h5A00; host_wdata = ~d; host_wr = ~wr;
            host_req = 1'b1;
        end else begin
            host_req = 1'b0;
        end
        @(posedge clk);
        #1 host_req = 1'b0;
        cyc = 0;
        while (!all_done() && n_wd == 0) begin
            @(posedge clk);
            #1;
            cyc++;
            if (cyc > 300) begin
                n_wd = 1;
                $display("FAIL watchdog: actual %0d cycles expected <= 300", cyc);
            end
        end
        repeat (2) @(posedge clk);
    endtask

    initial begin
        int tot, bad;
        void'($urandom(32'd20240611));
        do_reset();
        // Directed corners
        run_tx(1'b1, 16'h1230, 32'hA1B2_C3D4, 1'b0);   // R4 lane order
        run_tx(1'b0, 16'h4563, 32'h0, 1'b0);           // R7 lane from address 3
        run_tx(1'b0, 16'h7802, 32'h0, 1'b1);           // R9 drop while busy
        run_tx(1'b1, 16'h0001, 32'hFFFF_0000, 1'b1);
        for (int n = 0; n < 60 && n_wd == 0; n++) begin
            run_tx(1'($urandom), 16'($urandom), $urandom, ($urandom % 4) == 0);
        end
        do_reset();
        tot = n_wd + g_dut[0].n_chk + g_dut[1].n_chk + g_dut[2].n_chk
            + g_dut[3].n_chk + g_dut[4].n_chk;
        bad = n_wd + g_dut[0].n_bad + g_dut[1].n_bad + g_dut[2].n_bad
            + g_dut[3].n_bad + g_dut[4].n_bad;
        $display("[TB] %0d tests run, %0d failed", tot, bad);
        $finish;
    end

endmodule